// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is an 18-bit first-in first-out buffer. Its write port and its read port run on unrelated clocks. Pointers cross between the two domains as gray codes through two-flop synchronizers. The write domain computes the full, half-full and almost-full flags, and the read domain computes the empty and almost-empty flags. The depth is a power of two given by `ADDR_W` (16 words by default).

A master reset empties the buffer and latches two settings. The first is the read-timing mode: standard, or first-word-fall-through. The second is which of two preset offsets the almost flags start from. A partial reset empties the buffer and keeps the offsets and the mode. The two offsets can be rewritten in two ways:
- in parallel over the low data bits while the load strobe is high;
- serially, one bit per write clock.

A retransmit rewinds the read side to the first word written since the last reset. An output enable gates the read data and marks it as not driven.

In standard mode the two main flags mean "empty" and "full", and a read request moves a word into the output register. In first-word-fall-through mode they mean "output ready" and "input ready", and the output register is refilled automatically. The occupancy used by every flag counts the words held in the RAM. A word already moved into the output register is not counted.

Top module: `dcfifo_pf`

## Requirements
- R1: After master reset, in standard mode `rd_flag`=1 (empty) and `wr_flag`=0 (not full). In fall-through mode `rd_flag`=0 (not ready) and `wr_flag`=1 (ready). In both modes `half_full`=0, `almost_full`=0, `almost_empty`=1 and `dout`=0.
- R2: In standard mode, words come out in the order written, across both clocks. A read request sampled high on a read-clock rising edge places the next word on `dout` at that edge.
- R3: The full condition holds when the occupancy equals the depth. A write attempted while full is ignored: after the buffer is drained, the extra word never appears.
- R4: A read attempted while empty is ignored. `dout` keeps its value and the read position does not advance.
- R5: `half_full` is 1 exactly when the occupancy is greater than half the depth.
- R6: `almost_empty` is 1 when the occupancy is at or below the empty offset. `almost_full` is 1 when the occupancy is at or above the depth minus the full offset. At master reset both offsets take `DEF_OFF1` (=4) if `def_hi_sel`=1, or `DEF_OFF0` (=2) otherwise.
- R7: While `ld`=1, each write strobe stores `din[ADDR_W-1:0]` into an offset instead of the buffer. The first strobe after any reset writes the empty offset, the next writes the full offset, and they alternate from then on.
- R8: While `sen`=1 and `ld`=0, each write clock shifts `si` into the LSB of the concatenation {empty offset, full offset}. Bits are therefore sent starting with the MSB of the empty offset.
- R9: Partial reset empties the buffer and clears stored data. The offsets and the timing mode are left unchanged.
- R10: In fall-through mode, a word written into an empty buffer appears on `dout` with `rd_flag`=1 on the third read-clock rising edge after the write edge, with no read request. The word stays there until it is read. `wr_flag` is the inverse of the full condition.
- R11: Retransmit rewinds reading to the first word written since the last reset. In standard mode the next read returns that word. In fall-through mode `rd_flag` is 0 after the retransmit edge, and that word is valid after the following edge.
- R12: With `oe`=0, `dout` reads 0 and `dout_drv`=0. With `oe`=1, the registered word is shown on `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous in each domain |
| prst | input | 1 | Partial reset, keeps offsets and mode |
| mode_fwft | input | 1 | Timing mode sampled at master reset (1 = fall-through) |
| def_hi_sel | input | 1 | Default offset choice sampled at master reset |
| wen | input | 1 | Write strobe |
| din | input | 18 | Write data, low bits also carry parallel offset loads |
| ld | input | 1 | Parallel offset load enable |
| sen | input | 1 | Serial offset shift enable |
| si | input | 1 | Serial offset data |
| ren | input | 1 | Read strobe |
| rt | input | 1 | Retransmit request |
| oe | input | 1 | Output enable |
| dout | output | 18 | Read data, zero when not enabled |
| dout_drv | output | 1 | High when `dout` is driven |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | Occupancy above half depth |
| almost_empty | output | 1 | Occupancy at or below empty offset |
| almost_full | output | 1 | Occupancy at or above depth minus full offset |

## Verification
A table of fill levels is applied: 1, 3, 8, 9, 14 and 16 words, each from its own seed value. Each level is read back completely. These levels fall on either side of the default almost-empty, half-full, almost-full and full thresholds, so an off-by-one in any comparison shows up as a wrong flag at one level. Directed sequences follow:
- Overfill and over-read, to show that ignored accesses leave no trace.
- Offsets loaded in parallel, then serially, with the almost flags probed one word either side of each new threshold. A partial reset between the loads shows that the offsets survive it.
- The fall-through latency is counted edge by edge. Retransmit is tried in both modes, and the output enable is toggled last.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic {
        TM_STD  = 1'b0,
        TM_FWFT = 1'b1
    } tmode_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_offsets.sv
module dcf_offsets #(
    parameter int AW       = 4,
    parameter int DEF_OFF0 = 2,
    parameter int DEF_OFF1 = 4
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          def_hi_sel,
    input  logic          ld,
    input  logic          wen,
    input  logic [AW-1:0] pdata,
    input  logic          sen,
    input  logic          si,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);
    logic sel_full;

    always_ff @(posedge clk) begin
        if (mrst) begin
            ae_off   <= def_hi_sel ? AW'(DEF_OFF1) : AW'(DEF_OFF0);
            af_off   <= def_hi_sel ? AW'(DEF_OFF1) : AW'(DEF_OFF0);
            sel_full <= 1'b0;
        end else if (prst) begin
            sel_full <= 1'b0;
        end else if (ld && wen) begin
            if (sel_full) af_off <= pdata;
            else          ae_off <= pdata;
            sel_full <= ~sel_full;
        end else if (sen && !ld) begin
            {ae_off, af_off} <= {ae_off[AW-2:0], af_off, si};
        end
    end

    // R9: partial reset leaves both offsets as they were
    p_offsets_kept_r9: assert property (@(posedge clk) disable iff (mrst)
        prst |=> ($stable(ae_off) && $stable(af_off)));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          mode_fwft,
    input  logic          ren,
    input  logic          rt,
    input  logic [AW:0]   wr_bin_s,
    input  logic [AW-1:0] ae_off,
    output logic [AW:0]   rd_bin,
    output logic [AW:0]   rd_gray,
    output logic          take,
    output logic          out_valid,
    output logic          ram_empty,
    output logic          almost_empty,
    output tmode_e        mode
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rcount;
    logic [PW-1:0] rd_next;

    assign rcount       = wr_bin_s - rd_bin;
    assign ram_empty    = (rcount == '0);
    assign almost_empty = (rcount <= PW'(ae_off));

    always_comb begin
        if (mode == TM_FWFT) take = !ram_empty && !rt && (!out_valid || ren);
        else                 take = !ram_empty && !rt && ren;
        rd_next = rt ? '0 : rd_bin + PW'(take);
    end

    always_ff @(posedge clk) begin
        if (mrst) mode <= mode_fwft ? TM_FWFT : TM_STD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bin    <= '0;
            rd_gray   <= '0;
            out_valid <= 1'b0;
        end else begin
            rd_bin  <= rd_next;
            rd_gray <= PW'(bin2gray(32'(rd_next)));
            if (rt)        out_valid <= 1'b0;
            else if (take) out_valid <= 1'b1;
            else if (ren)  out_valid <= 1'b0;
        end
    end

    // R4: nothing leaves an empty RAM
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (ram_empty && !rt) |=> $stable(rd_bin));
    // R11: retransmit rewinds to the first location
    p_rt_rewind_r11: assert property (@(posedge clk) disable iff (rst)
        rt |=> (rd_bin == '0));
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf
    import dcf_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 18,
    parameter int DEF_OFF0 = 2,
    parameter int DEF_OFF1 = 4
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              prst,
    input  logic              mode_fwft,
    input  logic              def_hi_sel,
    input  logic              wen,
    input  logic [DATA_W-1:0] din,
    input  logic              ld,
    input  logic              sen,
    input  logic              si,
    input  logic              ren,
    input  logic              rt,
    input  logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drv,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic any_rst;
    assign any_rst = mrst | prst;

    logic [DATA_W-1:0] mem [DEPTH];

    // ---------------- write domain ----------------
    logic [PW-1:0]     wr_bin, wr_gray, wr_next, rd_gray_w, rd_bin_w, wcount;
    logic [ADDR_W-1:0] ae_off, af_off;
    logic              full, wr_ok;
    tmode_e            w_mode;

    dcf_offsets #(.AW(ADDR_W), .DEF_OFF0(DEF_OFF0), .DEF_OFF1(DEF_OFF1)) u_offs (
        .clk(wclk), .mrst(mrst), .prst(prst), .def_hi_sel(def_hi_sel),
        .ld(ld), .wen(wen), .pdata(din[ADDR_W-1:0]), .sen(sen), .si(si),
        .ae_off(ae_off), .af_off(af_off)
    );

    dcf_sync #(.W(PW)) u_sync_r2w (
        .clk(wclk), .rst(any_rst), .d(rd_gray), .q(rd_gray_w)
    );

    assign rd_bin_w    = PW'(gray2bin(32'(rd_gray_w)));
    assign wcount      = wr_bin - rd_bin_w;
    assign full        = (wcount == PW'(DEPTH));
    assign half_full   = (wcount > PW'(DEPTH / 2));
    assign almost_full = (wcount >= (PW'(DEPTH) - PW'(af_off)));
    assign wr_ok       = wen && !ld && !full;
    assign wr_next     = wr_bin + PW'(wr_ok);
    assign wr_flag     = (w_mode == TM_FWFT) ? !full : full;

    always_ff @(posedge wclk) begin
        if (mrst) w_mode <= mode_fwft ? TM_FWFT : TM_STD;
    end

    always_ff @(posedge wclk) begin
        if (any_rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            wr_bin  <= wr_next;
            wr_gray <= PW'(bin2gray(32'(wr_next)));
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_ok) mem[wr_bin[ADDR_W-1:0]] <= din;
    end

    // R3: a full buffer accepts nothing
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (any_rst)
        full |=> $stable(wr_bin));

    // ---------------- read domain ----------------
    logic [PW-1:0]     wr_gray_r, wr_bin_r, rd_bin, rd_gray;
    logic              take, out_valid, ram_empty;
    logic [DATA_W-1:0] q_reg;
    tmode_e            r_mode;

    dcf_sync #(.W(PW)) u_sync_w2r (
        .clk(rclk), .rst(any_rst), .d(wr_gray), .q(wr_gray_r)
    );

    assign wr_bin_r = PW'(gray2bin(32'(wr_gray_r)));

    dcf_rd_ctl #(.AW(ADDR_W)) u_rd (
        .clk(rclk), .rst(any_rst), .mrst(mrst), .mode_fwft(mode_fwft),
        .ren(ren), .rt(rt), .wr_bin_s(wr_bin_r), .ae_off(ae_off),
        .rd_bin(rd_bin), .rd_gray(rd_gray), .take(take), .out_valid(out_valid),
        .ram_empty(ram_empty), .almost_empty(almost_empty), .mode(r_mode)
    );

    always_ff @(posedge rclk) begin
        if (any_rst)   q_reg <= '0;
        else if (take) q_reg <= mem[rd_bin[ADDR_W-1:0]];
    end

    assign rd_flag  = (r_mode == TM_FWFT) ? out_valid : ram_empty;
    assign dout     = oe ? q_reg : '0;
    assign dout_drv = oe;

    // R10: a presented fall-through word holds until it is consumed
    p_fwft_hold_r10: assert property (@(posedge rclk) disable iff (any_rst)
        ((r_mode == TM_FWFT) && out_valid && !ren && !rt) |=> $stable(q_reg));
endmodule

// File: tb/test_dcfifo_pf.sv
`timescale 1ns/10ps
module test_dcfifo_pf;
    logic wclk = 0, rclk = 0;
    logic mrst = 0, prst = 0, mode_fwft = 0, def_hi_sel = 0;
    logic wen = 0, ld = 0, sen = 0, si = 0, ren = 0, rt = 0, oe = 1;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic dout_drv, rd_flag, wr_flag, half_full, almost_empty, almost_full;
    int nchecks = 0, nfail = 0;

    always #2.5 wclk = ~wclk;   // 200 MHz write clock
    always #4   rclk = ~rclk;

    dcfifo_pf i_dcfifo_pf (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .mode_fwft(mode_fwft),
        .def_hi_sel(def_hi_sel), .wen(wen), .din(din), .ld(ld), .sen(sen), .si(si),
        .ren(ren), .rt(rt), .oe(oe), .dout(dout), .dout_drv(dout_drv),
        .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    // {word count, first data value}
    localparam logic [22:0] VEC [6] = '{
        {5'd1,  18'h00011}, {5'd3,  18'h0A000}, {5'd8,  18'h3FFF0},
        {5'd9,  18'h12340}, {5'd14, 18'h2AAA0}, {5'd16, 18'h05550}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic wr(input logic [17:0] d);
        @(negedge wclk); din = d; wen = 1;
        @(negedge wclk); wen = 0;
    endtask

    task automatic rd();
        @(negedge rclk); ren = 1;
        @(negedge rclk); ren = 0;
    endtask

    task automatic do_mrst(input logic fw, input logic hi);
        @(negedge wclk); mode_fwft = fw; def_hi_sel = hi; mrst = 1;
        repeat (4) @(negedge rclk); mrst = 0;
        settle();
    endtask

    task automatic do_prst();
        @(negedge wclk); prst = 1;
        repeat (4) @(negedge rclk); prst = 0;
        settle();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] sbits;
        do_mrst(0, 0);
        chk("R1 empty", rd_flag, 1);      chk("R1 full", wr_flag, 0);
        chk("R1 hf", half_full, 0);       chk("R1 ae", almost_empty, 1);
        chk("R1 af", almost_full, 0);     chk("R1 dout", dout, 0);

        // table of fill levels, default offsets 2/2
        for (int v = 0; v < 6; v++) begin
            int n;
            logic [17:0] seed;
            n = int'(VEC[v][22:18]);
            seed = VEC[v][17:0];
            for (int i = 0; i < n; i++) wr(seed + 18'(i));
            settle();
            chk("R3 full", wr_flag, 32'(n == 16));
            chk("R5 half", half_full, 32'(n > 8));
            chk("R6 ae", almost_empty, 32'(n <= 2));
            chk("R6 af", almost_full, 32'(n >= 14));
            chk("R2 not empty", rd_flag, 0);
            for (int i = 0; i < n; i++) begin
                rd();
                chk("R2 data", dout, 32'(seed + 18'(i)));
            end
            settle();
            chk("R2 drained", rd_flag, 1);
        end

        // R3 overfill
        for (int i = 0; i < 16; i++) wr(18'h100 + 18'(i));
        settle();
        chk("R3 full", wr_flag, 1);
        wr(18'h3ABCD);
        settle();
        for (int i = 0; i < 16; i++) begin
            rd();
            chk("R3 data", dout, 32'(18'h100 + 18'(i)));
        end
        settle();
        chk("R3 extra dropped", rd_flag, 1);
        chk("R3 not full", wr_flag, 0);
        // R4 read while empty
        rd();
        chk("R4 dout held", dout, 32'h10F);
        wr(18'h55); settle(); rd();
        chk("R4 next word", dout, 32'h55);
        settle();

        // R7 parallel load: empty offset 5, full offset 10 (threshold 6)
        ld = 1; wr(18'h5); wr(18'hA); ld = 0;
        settle();
        chk("R7 no data stored", rd_flag, 1);
        for (int i = 0; i < 5; i++) wr(18'h20 + 18'(i));
        settle();
        chk("R7 ae at 5", almost_empty, 1); chk("R7 af at 5", almost_full, 0);
        wr(18'h25); settle();
        chk("R7 ae at 6", almost_empty, 0); chk("R7 af at 6", almost_full, 1);

        // R9 partial reset keeps offsets
        do_prst();
        chk("R9 empty", rd_flag, 1); chk("R9 af", almost_full, 0);
        for (int i = 0; i < 6; i++) wr(18'h200 + 18'(i));
        settle();
        chk("R9 af kept", almost_full, 1); chk("R9 ae kept", almost_empty, 0);
        rd();
        chk("R9 first word", dout, 32'h200);

        // R8 serial load: empty offset 3, full offset 12 (threshold 4)
        do_prst();
        sbits = 8'b0011_1100;
        for (int b = 7; b >= 0; b--) begin
            @(negedge wclk); sen = 1; si = sbits[b];
        end
        @(negedge wclk); sen = 0; si = 0;
        for (int i = 0; i < 3; i++) wr(18'h300 + 18'(i));
        settle();
        chk("R8 ae at 3", almost_empty, 1); chk("R8 af at 3", almost_full, 0);
        wr(18'h303); settle();
        chk("R8 ae at 4", almost_empty, 0); chk("R8 af at 4", almost_full, 1);

        // R11 retransmit, standard mode
        rd(); rd();
        chk("R11 second", dout, 32'h301);
        @(negedge rclk); rt = 1; @(negedge rclk); rt = 0;
        rd();
        chk("R11 std replay", dout, 32'h300);

        // R6 high default offsets (4)
        do_mrst(0, 1);
        for (int i = 0; i < 4; i++) wr(18'h400 + 18'(i));
        settle(); chk("R6 hi ae at 4", almost_empty, 1);
        wr(18'h404); settle(); chk("R6 hi ae at 5", almost_empty, 0);
        for (int i = 0; i < 6; i++) wr(18'h405 + 18'(i));
        settle(); chk("R6 hi af at 11", almost_full, 0);
        wr(18'h40B); settle(); chk("R6 hi af at 12", almost_full, 1);

        // R10 fall-through mode
        do_mrst(1, 0);
        chk("R1 fwft ready", rd_flag, 0); chk("R10 input ready", wr_flag, 1);
        @(negedge wclk); din = 18'h0ABC; wen = 1;
        @(posedge wclk); #0.1 wen = 0;
        @(posedge rclk); @(posedge rclk);
        @(negedge rclk); chk("R10 not yet ready", rd_flag, 0);
        @(posedge rclk);
        @(negedge rclk); chk("R10 ready edge 3", rd_flag, 1);
        chk("R10 word", dout, 32'h0ABC);
        repeat (5) @(negedge rclk);
        chk("R10 held", dout, 32'h0ABC);
        wr(18'h0ABD); wr(18'h0ABE); settle();
        rd(); chk("R10 next", dout, 32'h0ABD);
        rd(); chk("R10 last", dout, 32'h0ABE);
        rd(); chk("R10 drained", rd_flag, 0);

        // R11 retransmit, fall-through mode
        @(negedge rclk); rt = 1;
        @(negedge rclk); rt = 0; chk("R11 fwft gap", rd_flag, 0);
        @(negedge rclk); chk("R11 fwft ready", rd_flag, 1);
        chk("R11 fwft replay", dout, 32'h0ABC);

        // R12 output enable
        @(negedge rclk); oe = 0; #1;
        chk("R12 dout off", dout, 0); chk("R12 drv off", dout_drv, 0);
        oe = 1; #1;
        chk("R12 dout on", dout, 32'h0ABC); chk("R12 drv on", dout_drv, 1);

        summary();
    end
endmodule